// File: doc/BRIEF.md
# Input Capture Channel

This block timestamps transitions on an asynchronous input line against a free-running up counter. The counter advances by one every clock and returns to zero after it reaches a programmable reload value. The input is brought into the clock domain through a chain of flip-flops. A transition of the chosen polarity, or a transition of either polarity, is an event. On each event the current count is latched into a capture register and a sticky event flag is raised.

Software reads the latched count. It subtracts successive readings to get the time between events, such as the period of a tachometer signal. It then clears the flag with a one-cycle clear pulse. An interrupt line presents the flag whenever the interrupt enable is high. A global capture enable stops all latching while it is low.

Top module: `icap_channel`

## Requirements
- R1: After reset `count` is 0. While `count` differs from `reload_val`, it grows by exactly one on every clock.
- R2: When `count` equals `reload_val`, the next clock returns `count` to 0.
- R3: A change on `sig_in`, held stable, is detected after two synchronizer stages. `cap_value` is loaded on the third rising edge after the change with the `count` value present between the second and third edges.
- R4: With `edge_sel` = 2'b00, only high-to-low transitions of `sig_in` cause a capture.
- R5: With `edge_sel` = 2'b01, only low-to-high transitions of `sig_in` cause a capture.
- R6: With `edge_sel` = 2'b11, transitions of both polarities cause a capture.
- R7: With `edge_sel` = 2'b10, no transition causes a capture. `cap_value` and `cap_flag` stay as they were.
- R8: While `cap_en` is 0, no capture occurs. `cap_value` and `cap_flag` stay as they were.
- R9: `cap_flag` is set by every capture and remains set until a clock on which `flag_clr` is 1 and no capture occurs, which clears it. `cap_value` changes only together with a set flag.
- R10: When a capture and `flag_clr` fall on the same clock, the capture wins: `cap_flag` is 1 afterwards and `cap_value` holds the new count.
- R11: `irq` equals `cap_flag` AND `irq_en` at all times.
- R12: After reset `cap_value` is 0, `cap_flag` is 0 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reload_val | input | 16 | Last count value before the counter wraps to 0 |
| sig_in | input | 1 | Asynchronous input whose transitions are timestamped |
| edge_sel | input | 2 | Event polarity: 00 falling, 01 rising, 10 none, 11 both |
| cap_en | input | 1 | Capture enable |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | One-cycle pulse that clears the capture flag |
| count | output | 16 | Running counter value |
| cap_value | output | 16 | Count latched at the most recent event |
| cap_flag | output | 1 | Sticky capture event flag |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a capture and a software clear landing on the same clock. The bench gets there by counting synchronizer stages from a transition it drives on `sig_in`. It raises `flag_clr` exactly in the cycle before the third edge, so the flag is set and cleared on one edge. Every table vector also predicts the captured value from the `count` port, sampled in the cycle before the capture edge. This pins down the synchronizer latency without looking inside the design.

// File: rtl/icap_pkg.sv
package icap_pkg;

   // Event polarity codes on edge_sel
   localparam logic [1:0] EDGE_FALL = 2'b00;
   localparam logic [1:0] EDGE_RISE = 2'b01;
   localparam logic [1:0] EDGE_NONE = 2'b10;
   localparam logic [1:0] EDGE_BOTH = 2'b11;

   typedef struct packed {
      logic rise;
      logic fall;
   } edge_pair_t;

endpackage

// File: rtl/icap_counter.sv
module icap_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] reload_val,
   output logic [CNT_W-1:0] count
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_d;
   logic             at_top;

   assign at_top = (cnt_q == reload_val);

   always_comb begin
      if (at_top) cnt_d = '0;
      else        cnt_d = cnt_q + ONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end

   assign count = cnt_q;

endmodule

// File: rtl/icap_edge_detect.sv
module icap_edge_detect
   import icap_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sig_async,
   input  logic [1:0] edge_sel,
   output logic       event_hit
);

   localparam int LAST = SYNC_STAGES - 1;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_stages
         $error("icap_edge_detect: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   edge_pair_t             edges;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[0] <= 1'b0;
      else        sync_q[0] <= sig_async;
   end

   generate
      for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q[s] <= 1'b0;
            else        sync_q[s] <= sync_q[s-1];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sync_q[LAST];
   end

   assign edges.rise = sync_q[LAST] & ~prev_q;
   assign edges.fall = ~sync_q[LAST] & prev_q;

   always_comb begin
      case (edge_sel)
         EDGE_FALL: event_hit = edges.fall;
         EDGE_RISE: event_hit = edges.rise;
         EDGE_BOTH: event_hit = edges.rise | edges.fall;
         default:   event_hit = 1'b0;
      endcase
   end

endmodule

// File: rtl/icap_capture_reg.sv
module icap_capture_reg #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   input  logic             flag_clr,
   input  logic [CNT_W-1:0] count,
   output logic [CNT_W-1:0] cap_value,
   output logic             cap_flag
);

   logic [CNT_W-1:0] val_q;
   logic             flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    val_q <= '0;
      else if (take) val_q <= count;
   end

   // A capture on the same edge as a clear leaves the flag set
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag_q <= 1'b0;
      else if (take)     flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
   end

   assign cap_value = val_q;
   assign cap_flag  = flag_q;

endmodule

// File: rtl/icap_channel.sv
module icap_channel #(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] reload_val,
   input  logic             sig_in,
   input  logic [1:0]       edge_sel,
   input  logic             cap_en,
   input  logic             irq_en,
   input  logic             flag_clr,
   output logic [CNT_W-1:0] count,
   output logic [CNT_W-1:0] cap_value,
   output logic             cap_flag,
   output logic             irq
);

   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("icap_channel: CNT_W must be at least 2");
      end
   endgenerate

   logic event_hit;
   logic take;

   icap_counter #(.CNT_W(CNT_W)) u_counter (
      .clk        (clk),
      .rst_n      (rst_n),
      .reload_val (reload_val),
      .count      (count)
   );

   icap_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk       (clk),
      .rst_n     (rst_n),
      .sig_async (sig_in),
      .edge_sel  (edge_sel),
      .event_hit (event_hit)
   );

   assign take = event_hit & cap_en;

   icap_capture_reg #(.CNT_W(CNT_W)) u_capture (
      .clk       (clk),
      .rst_n     (rst_n),
      .take      (take),
      .flag_clr  (flag_clr),
      .count     (count),
      .cap_value (cap_value),
      .cap_flag  (cap_flag)
   );

   assign irq = cap_flag & irq_en;

endmodule

// File: rtl/icap_channel_chk.sv
module icap_channel_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CNT_W-1:0] reload_val,
   input logic [1:0]       edge_sel,
   input logic             cap_en,
   input logic             irq_en,
   input logic             flag_clr,
   input logic [CNT_W-1:0] count,
   input logic [CNT_W-1:0] cap_value,
   input logic             cap_flag,
   input logic             irq
);

   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (count != reload_val) |=> (count == CNT_W'($past(count) + 1'b1))); // R1

   AST_COUNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (count == reload_val) |=> (count == '0)); // R2

   AST_NONE_CODE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_sel == 2'b10) |=> ($stable(cap_value) && !$rose(cap_flag))); // R7

   AST_DISABLED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!cap_en) |=> ($stable(cap_value) && !$rose(cap_flag))); // R8

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_flag && !flag_clr) |=> cap_flag); // R9

   AST_CLEAR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr && !cap_en) |=> !cap_flag); // R9

   AST_VALUE_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cap_value) |-> cap_flag); // R9

   AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      irq == (cap_flag & irq_en)); // R11

endmodule

bind icap_channel icap_channel_chk #(.CNT_W(CNT_W)) u_icap_channel_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .reload_val (reload_val),
   .edge_sel   (edge_sel),
   .cap_en     (cap_en),
   .irq_en     (irq_en),
   .flag_clr   (flag_clr),
   .count      (count),
   .cap_value  (cap_value),
   .cap_flag   (cap_flag),
   .irq        (irq)
);

// File: tb/icap_channel_bench.sv
`timescale 1ns/1ps
module icap_channel_bench;

   localparam int W = 16;
   localparam logic [W-1:0] TOP = 16'd40;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] reload_val = TOP;
   logic         sig_in = 1'b0;
   logic [1:0]   edge_sel = 2'b01;
   logic         cap_en = 1'b0;
   logic         irq_en = 1'b0;
   logic         flag_clr = 1'b0;
   logic [W-1:0] count;
   logic [W-1:0] cap_value;
   logic         cap_flag;
   logic         irq;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   icap_channel u_icap_channel (
      .clk(clk), .rst_n(rst_n), .reload_val(reload_val), .sig_in(sig_in),
      .edge_sel(edge_sel), .cap_en(cap_en), .irq_en(irq_en), .flag_clr(flag_clr),
      .count(count), .cap_value(cap_value), .cap_flag(cap_flag), .irq(irq)
   );

   // vector: [4:3] edge_sel, [2] cap_en, [1] new sig_in level, [0] capture expected
   localparam int NV = 12;
   localparam logic [4:0] VEC [NV] = '{
      5'b01_1_1_1, // R5 rise captured
      5'b01_1_0_0, // R5 fall ignored
      5'b00_1_1_0, // R4 rise ignored
      5'b00_1_0_1, // R4 fall captured
      5'b11_1_1_1, // R6 rise
      5'b11_1_0_1, // R6 fall
      5'b10_1_1_0, // R7
      5'b10_1_0_0, // R7
      5'b11_0_1_0, // R8
      5'b11_0_0_0, // R8
      5'b01_1_1_1, // R3 rise again
      5'b00_0_0_0  // R8
   };

   task automatic check(input string req, input bit ok,
                        input logic [W-1:0] act, input logic [W-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_cycles(input int n);
      for (int i = 0; i < n; i++) @(posedge clk);
      #1;
   endtask

   task automatic pulse_clear();
      @(negedge clk) flag_clr = 1'b1;
      @(negedge clk) flag_clr = 1'b0;
   endtask

   initial begin : watchdog
      #(200000 * 5);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : main
      logic [W-1:0] exp_val;
      logic [W-1:0] c0;
      // R12 / R1 reset state
      #12;
      check("R12 cap_value", cap_value == '0, cap_value, '0);
      check("R12 cap_flag", cap_flag == 1'b0, W'(cap_flag), '0);
      check("R12 irq", irq == 1'b0, W'(irq), '0);
      check("R1 count at reset", count == '0, count, '0);
      @(negedge clk) rst_n = 1'b1;
      // R1 stepping
      @(posedge clk); #1 c0 = count;
      wait_cycles(3);
      check("R1 step", count == c0 + 16'd3, count, c0 + 16'd3);
      // R2 wrap
      while (count != TOP) wait_cycles(1);
      wait_cycles(1);
      check("R2 wrap", count == '0, count, '0);

      // Table walk (R3..R9)
      exp_val = cap_value;
      for (int v = 0; v < NV; v++) begin
         logic [W-1:0] seen;
         @(negedge clk);
         edge_sel = VEC[v][4:3];
         cap_en   = VEC[v][2];
         pulse_clear();
         wait_cycles(2);
         @(negedge clk) sig_in = VEC[v][1];
         @(posedge clk);
         @(posedge clk); #1 seen = count;
         @(posedge clk); #1;
         if (VEC[v][0]) exp_val = seen;
         check($sformatf("R3 vec%0d cap_value", v), cap_value == exp_val, cap_value, exp_val);
         check($sformatf("R9 vec%0d cap_flag", v), cap_flag == VEC[v][0],
               W'(cap_flag), W'(VEC[v][0]));
         wait_cycles(3);
         check($sformatf("R9 vec%0d flag held", v), cap_flag == VEC[v][0],
               W'(cap_flag), W'(VEC[v][0]));
      end

      // R11 interrupt gating (flag is currently 0)
      @(negedge clk); edge_sel = 2'b01; cap_en = 1'b1; irq_en = 1'b0;
      sig_in = 1'b0;
      wait_cycles(4);
      @(negedge clk) sig_in = 1'b1;
      wait_cycles(4);
      check("R11 flag set", cap_flag == 1'b1, W'(cap_flag), 16'd1);
      check("R11 irq masked", irq == 1'b0, W'(irq), '0);
      @(negedge clk) irq_en = 1'b1; #1;
      check("R11 irq raised", irq == 1'b1, W'(irq), 16'd1);
      pulse_clear(); #1;
      check("R9 clear", cap_flag == 1'b0, W'(cap_flag), '0);
      check("R11 irq after clear", irq == 1'b0, W'(irq), '0);

      // R10 capture and clear on the same edge
      @(negedge clk) sig_in = 1'b0;
      wait_cycles(4);
      @(negedge clk) sig_in = 1'b1;
      @(posedge clk);
      @(posedge clk); #1 exp_val = count;
      @(negedge clk) flag_clr = 1'b1;
      @(posedge clk); #1;
      flag_clr = 1'b0;
      check("R10 flag kept", cap_flag == 1'b1, W'(cap_flag), 16'd1);
      check("R10 value", cap_value == exp_val, cap_value, exp_val);
      check("R11 irq on collision", irq == 1'b1, W'(irq), 16'd1);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule